// File: doc/BRIEF.md
# Plug-and-Play Configuration Unlock and Isolation Port

This block watches byte writes on a simple ISA-style write bus, aimed at one of two ports. One port carries addresses and the other carries write data. While the block is locked, it watches the address port for an unlock sequence. First come two 0x00 writes, which arm the checker. Then come 32 key bytes made by an 8-bit shift register. Only after the last key byte does the block open its configuration space. From then on, a register write is an address-port write that selects a register number, followed by a data-port write that loads the value.

The open configuration space holds the card number, the logical-device select and one activate flag per logical device. It also runs the serial isolation protocol. Software first writes register 0x00 to set up the read port, then writes the isolation command into register 0x01. After that, each read strobe on the read-data port returns one half of an identifier bit. Two reads carry one bit, so the 72-bit identifier takes 144 reads.

Top module: `pnp_init_key`

## Requirements
- R1: After reset, the outputs are as follows: `cfg_open`=0, `card_number`=0, `logical_dev`=0, `dev_active`=0, `isolating`=0 and `rd_byte`=0xFF.
- R2: The key is only recognised when it follows two back-to-back address-port writes of 0x00. If the key bytes arrive without that arming, the block stays locked.
- R3: The key has `KEY_LEN`=32 bytes and starts at 0x6A. Each next byte is the previous byte shifted right by one, with the new bit 7 set to old bit 0 XOR old bit 1. The last byte is 0x39. `cfg_open` rises on the clock edge that samples the last correct byte.
- R4: While armed, a byte that does not match sends the checker back to expecting 0x6A. The mismatching byte is not itself tested as a first byte.
- R5: While locked, data-port writes change no register.
- R6: When open, an address-port write selects the register and a data-port write loads it. Register 0x06 holds the card number and register 0x07 holds the logical-device select; each is updated on the edge that samples the data write.
- R7: A data write to register 0x30 copies bit 0 of the value into `dev_active[logical_dev]`. If `logical_dev` >= `NUM_DEV`, the write has no effect.
- R8: `rd_byte` returns 0xFF for any read while not isolating. Isolation starts on a data write of 0x01 to register 0x01, but only once register 0x00 has been written (with any value) since reset.
- R9: Identifier bit k is `ID_VALUE[k]`, so byte n is sent least significant bit first. Each bit takes two reads: a 1 answers 0x55 then 0xAA, and a 0 answers 0x00 then 0x00. `rd_byte` changes only on the edge that samples `rd_strobe`, and holds its value between reads.
- R10: After the 144th read, `isolating` drops and later reads return 0xFF.
- R11: A read in the same cycle as an isolation-start write is answered from the position before the write. The next read returns the first half of bit 0.
- R12: Once open, the block stays open until reset, whatever is written to the address port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_strobe | input | 1 | Byte write this cycle |
| wr_port | input | 1 | Write target: 0 address port, 1 write-data port |
| wr_byte | input | 8 | Write value |
| rd_strobe | input | 1 | Read of the read-data port this cycle |
| rd_byte | output | 8 | Registered read answer |
| cfg_open | output | 1 | Configuration space unlocked |
| isolating | output | 1 | Isolation readout in progress |
| card_number | output | 8 | Card number register |
| logical_dev | output | 8 | Logical-device select register |
| dev_active | output | NUM_DEV | Activate flag per logical device |

## Verification
The two functions that can share a cycle are a write on the write bus and a read of the read-data port. The hardest overlap is a data write that restarts isolation in the same cycle as an isolation read. The bench first reads partway into the identifier. It then drives both strobes together and checks two things. The concurrent read must be answered from the old bit position, and the following read must return the first half of bit 0. The reference model, updated on every edge, judges every other cycle of the run as well.

// File: rtl/pnp_key_pkg.sv
package pnp_key_pkg;

  typedef enum logic [1:0] {
    KS_IDLE  = 2'd0,
    KS_ZERO  = 2'd1,
    KS_ARMED = 2'd2
  } key_state_t;

  localparam logic [7:0] REG_RDPORT = 8'h00;
  localparam logic [7:0] REG_ISOL   = 8'h01;
  localparam logic [7:0] REG_CARD   = 8'h06;
  localparam logic [7:0] REG_LDEV   = 8'h07;
  localparam logic [7:0] REG_ACT    = 8'h30;

  localparam logic [7:0] RD_IDLE = 8'hFF;
  localparam logic [7:0] RD_ONE1 = 8'h55;
  localparam logic [7:0] RD_ONE2 = 8'hAA;
  localparam logic [7:0] RD_ZERO = 8'h00;

  // next key byte: shift right, new MSB is XOR of the two low bits
  function automatic logic [7:0] key_step(input logic [7:0] b);
    return {b[0] ^ b[1], b[7:1]};
  endfunction

endpackage

// File: rtl/pnp_key_checker.sv
module pnp_key_checker
  import pnp_key_pkg::*;
#(
  parameter int         KEY_LEN  = 32,
  parameter logic [7:0] KEY_SEED = 8'h6A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_wr,
  input  logic [7:0] wr_byte,
  output logic       cfg_open
);
  localparam int IDXW = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(KEY_LEN - 1);

  key_state_t      st_q, st_d;
  logic [IDXW-1:0] idx_q, idx_d;
  logic [7:0]      exp_q, exp_d;
  logic            open_q, open_d;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    exp_d  = exp_q;
    open_d = open_q;
    if (addr_wr && !open_q) begin
      unique case (st_q)
        KS_IDLE: begin
          if (wr_byte == 8'h00) st_d = KS_ZERO;
        end
        KS_ZERO: begin
          if (wr_byte == 8'h00) begin
            st_d  = KS_ARMED;
            idx_d = '0;
            exp_d = KEY_SEED;
          end else begin
            st_d = KS_IDLE;
          end
        end
        KS_ARMED: begin
          if (wr_byte == exp_q) begin
            if (idx_q == LAST_IDX) begin
              open_d = 1'b1;
              st_d   = KS_IDLE;
            end else begin
              idx_d = idx_q + 1'b1;
              exp_d = key_step(exp_q);
            end
          end else begin
            idx_d = '0;
            exp_d = KEY_SEED;
          end
        end
        default: st_d = KS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= KS_IDLE;
      idx_q  <= '0;
      exp_q  <= KEY_SEED;
      open_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      exp_q  <= exp_d;
      open_q <= open_d;
    end
  end

  assign cfg_open = open_q;

endmodule

// File: rtl/pnp_cfg_regs.sv
module pnp_cfg_regs
  import pnp_key_pkg::*;
#(
  parameter int         NUM_DEV = 8,
  parameter logic [7:0] ISO_CMD = 8'h01
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_open,
  input  logic               wr_strobe,
  input  logic               wr_port,
  input  logic [7:0]         wr_byte,
  output logic [7:0]         card_number,
  output logic [7:0]         logical_dev,
  output logic [NUM_DEV-1:0] dev_active,
  output logic               iso_start
);
  logic [7:0]         addr_q, addr_d;
  logic [7:0]         card_q, card_d;
  logic [7:0]         ldev_q, ldev_d;
  logic               rdset_q, rdset_d;
  logic [NUM_DEV-1:0] act_q, act_d;
  logic               data_wr, sel_wr;

  assign sel_wr  = cfg_open && wr_strobe && !wr_port;
  assign data_wr = cfg_open && wr_strobe && wr_port;

  always_comb begin
    addr_d  = addr_q;
    card_d  = card_q;
    ldev_d  = ldev_q;
    rdset_d = rdset_q;
    if (sel_wr) addr_d = wr_byte;
    if (data_wr) begin
      if (addr_q == REG_CARD)   card_d  = wr_byte;
      if (addr_q == REG_LDEV)   ldev_d  = wr_byte;
      if (addr_q == REG_RDPORT) rdset_d = 1'b1;
    end
  end

  assign iso_start = data_wr && (addr_q == REG_ISOL) && (wr_byte == ISO_CMD) && rdset_q;

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_act
    logic hit;
    assign hit      = data_wr && (addr_q == REG_ACT) && (ldev_q == 8'(g));
    assign act_d[g] = hit ? wr_byte[0] : act_q[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_q[g] <= 1'b0;
      else        act_q[g] <= act_d[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      card_q  <= '0;
      ldev_q  <= '0;
      rdset_q <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      card_q  <= card_d;
      ldev_q  <= ldev_d;
      rdset_q <= rdset_d;
    end
  end

  assign card_number = card_q;
  assign logical_dev = ldev_q;
  assign dev_active  = act_q;

endmodule

// File: rtl/pnp_isolation_reader.sv
module pnp_isolation_reader
  import pnp_key_pkg::*;
#(
  parameter int                    ID_BYTES = 9,
  parameter logic [ID_BYTES*8-1:0] ID_VALUE = '0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       iso_start,
  input  logic       rd_strobe,
  output logic [7:0] rd_byte,
  output logic       isolating
);
  localparam int ID_BITS = ID_BYTES * 8;
  localparam int KW      = $clog2(ID_BITS);
  localparam logic [KW-1:0] LAST_K = KW'(ID_BITS - 1);

  logic [KW-1:0] k_q, k_d;
  logic          half_q, half_d;
  logic          iso_q, iso_d;
  logic [7:0]    rd_q, rd_d;
  logic [7:0]    resp;
  logic          cur_bit;

  assign cur_bit = ID_VALUE[k_q];

  always_comb begin
    if (!iso_q)       resp = RD_IDLE;
    else if (cur_bit) resp = half_q ? RD_ONE2 : RD_ONE1;
    else              resp = RD_ZERO;
  end

  always_comb begin
    k_d    = k_q;
    half_d = half_q;
    iso_d  = iso_q;
    rd_d   = rd_strobe ? resp : rd_q;
    if (iso_start) begin
      iso_d  = 1'b1;
      k_d    = '0;
      half_d = 1'b0;
    end else if (rd_strobe && iso_q) begin
      if (half_q) begin
        half_d = 1'b0;
        if (k_q == LAST_K) begin
          iso_d = 1'b0;
          k_d   = '0;
        end else begin
          k_d = k_q + 1'b1;
        end
      end else begin
        half_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q    <= '0;
      half_q <= 1'b0;
      iso_q  <= 1'b0;
      rd_q   <= RD_IDLE;
    end else begin
      k_q    <= k_d;
      half_q <= half_d;
      iso_q  <= iso_d;
      rd_q   <= rd_d;
    end
  end

  assign rd_byte   = rd_q;
  assign isolating = iso_q;

endmodule

// File: rtl/pnp_init_key.sv
module pnp_init_key #(
  parameter int                    NUM_DEV  = 8,
  parameter int                    KEY_LEN  = 32,
  parameter logic [7:0]            KEY_SEED = 8'h6A,
  parameter logic [7:0]            ISO_CMD  = 8'h01,
  parameter int                    ID_BYTES = 9,
  parameter logic [ID_BYTES*8-1:0] ID_VALUE = 72'h5DC8247BE10F963CA9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_strobe,
  input  logic               wr_port,
  input  logic [7:0]         wr_byte,
  input  logic               rd_strobe,
  output logic [7:0]         rd_byte,
  output logic               cfg_open,
  output logic               isolating,
  output logic [7:0]         card_number,
  output logic [7:0]         logical_dev,
  output logic [NUM_DEV-1:0] dev_active
);
  logic addr_wr;
  logic iso_start;

  assign addr_wr = wr_strobe && !wr_port;

  pnp_key_checker #(
    .KEY_LEN  (KEY_LEN),
    .KEY_SEED (KEY_SEED)
  ) u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_wr  (addr_wr),
    .wr_byte  (wr_byte),
    .cfg_open (cfg_open)
  );

  pnp_cfg_regs #(
    .NUM_DEV (NUM_DEV),
    .ISO_CMD (ISO_CMD)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_open    (cfg_open),
    .wr_strobe   (wr_strobe),
    .wr_port     (wr_port),
    .wr_byte     (wr_byte),
    .card_number (card_number),
    .logical_dev (logical_dev),
    .dev_active  (dev_active),
    .iso_start   (iso_start)
  );

  pnp_isolation_reader #(
    .ID_BYTES (ID_BYTES),
    .ID_VALUE (ID_VALUE)
  ) u_iso (
    .clk       (clk),
    .rst_n     (rst_n),
    .iso_start (iso_start),
    .rd_strobe (rd_strobe),
    .rd_byte   (rd_byte),
    .isolating (isolating)
  );

endmodule

// File: rtl/pnp_init_key_chk.sv
module pnp_init_key_chk #(
  parameter int NUM_DEV = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_strobe,
  input logic               wr_port,
  input logic               rd_strobe,
  input logic [7:0]         rd_byte,
  input logic               cfg_open,
  input logic               isolating,
  input logic [7:0]         card_number,
  input logic [7:0]         logical_dev,
  input logic [NUM_DEV-1:0] dev_active
);

  assert_open_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_open |=> cfg_open);

  assert_open_on_addr_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(wr_strobe && !wr_port));

  assert_card_needs_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(card_number) |-> $past(wr_strobe && wr_port && cfg_open));

  assert_ldev_needs_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(logical_dev) |-> $past(wr_strobe && wr_port && cfg_open));

  assert_active_needs_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dev_active) |-> $past(wr_strobe && wr_port && cfg_open));

  assert_active_one_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dev_active ^ $past(dev_active)) <= 1);

  assert_iso_needs_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(isolating) |-> $past(wr_strobe && wr_port && cfg_open));

  assert_idle_reads_ff_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !isolating) |=> (rd_byte == 8'hFF));

  assert_rd_codes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_byte == 8'hFF) || (rd_byte == 8'h55) || (rd_byte == 8'hAA) || (rd_byte == 8'h00));

  assert_rd_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_byte) |-> $past(rd_strobe));

  assert_iso_ends_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(isolating) |-> $past(rd_strobe));

endmodule

bind pnp_init_key pnp_init_key_chk #(.NUM_DEV(NUM_DEV)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_strobe   (wr_strobe),
  .wr_port     (wr_port),
  .rd_strobe   (rd_strobe),
  .rd_byte     (rd_byte),
  .cfg_open    (cfg_open),
  .isolating   (isolating),
  .card_number (card_number),
  .logical_dev (logical_dev),
  .dev_active  (dev_active)
);

// File: tb/tb_pnp_init_key.sv
`timescale 1ns/1ps
module tb_pnp_init_key;
  localparam int          NDEV = 8;
  localparam logic [71:0] ID   = 72'h5DC8247BE10F963CA9;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_strobe = 1'b0;
  logic            wr_port = 1'b0;
  logic [7:0]      wr_byte = 8'h00;
  logic            rd_strobe = 1'b0;
  logic [7:0]      rd_byte;
  logic            cfg_open, isolating;
  logic [7:0]      card_number, logical_dev;
  logic [NDEV-1:0] dev_active;

  always #5 clk = ~clk;

  pnp_init_key dut (
    .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .wr_port(wr_port),
    .wr_byte(wr_byte), .rd_strobe(rd_strobe), .rd_byte(rd_byte),
    .cfg_open(cfg_open), .isolating(isolating), .card_number(card_number),
    .logical_dev(logical_dev), .dev_active(dev_active)
  );

  int    errors = 0;
  int    checks = 0;
  bit    live = 0;
  bit    done = 0;
  string cur_req = "R1";
  logic [7:0] key_tab [32];

  // reference model state
  int         m_mode;   // 0 wait zero, 1 one zero seen, 2 armed
  int         m_idx;
  bit         m_open, m_rdset, m_iso, m_half;
  int         m_k;
  logic [7:0] m_addr, m_card, m_ldev, m_rd;
  logic [NDEV-1:0] m_act;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_idx = 0; m_open = 0; m_rdset = 0; m_iso = 0; m_half = 0;
      m_k = 0; m_addr = 0; m_card = 0; m_ldev = 0; m_rd = 8'hFF; m_act = '0;
    end else begin
      bit start;
      start = 0;
      if (rd_strobe) begin
        if (!m_iso)      m_rd = 8'hFF;
        else if (ID[m_k]) m_rd = m_half ? 8'hAA : 8'h55;
        else              m_rd = 8'h00;
      end
      if (wr_strobe) begin
        if (!m_open) begin
          if (!wr_port) begin
            if (m_mode == 2) begin
              if (wr_byte == key_tab[m_idx]) begin
                if (m_idx == 31) begin m_open = 1; m_mode = 0; end
                else m_idx++;
              end else m_idx = 0;
            end else if (wr_byte == 8'h00) begin
              if (m_mode == 1) begin m_mode = 2; m_idx = 0; end
              else m_mode = 1;
            end else m_mode = 0;
          end
        end else if (!wr_port) begin
          m_addr = wr_byte;
        end else begin
          case (m_addr)
            8'h00: m_rdset = 1;
            8'h01: if (wr_byte == 8'h01 && m_rdset) start = 1;
            8'h06: m_card = wr_byte;
            8'h07: m_ldev = wr_byte;
            8'h30: if (m_ldev < NDEV) m_act[m_ldev] = wr_byte[0];
            default: ;
          endcase
        end
      end
      if (start) begin
        m_iso = 1; m_k = 0; m_half = 0;
      end else if (rd_strobe && m_iso) begin
        if (m_half) begin
          m_half = 0;
          if (m_k == 71) begin m_iso = 0; m_k = 0; end
          else m_k++;
        end else m_half = 1;
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (live && rst_n && !done) begin
      check(rd_byte === m_rd,      cur_req, "model rd_byte",     rd_byte, m_rd);
      check(cfg_open === m_open,   cur_req, "model cfg_open",    cfg_open, m_open);
      check(isolating === m_iso,   cur_req, "model isolating",   isolating, m_iso);
      check(card_number === m_card, cur_req, "model card_number", card_number, m_card);
      check(logical_dev === m_ldev, cur_req, "model logical_dev", logical_dev, m_ldev);
      check(dev_active === m_act,  cur_req, "model dev_active",  dev_active, m_act);
    end
  end

  task automatic wr(input bit p, input logic [7:0] b);
    wr_strobe = 1'b1; wr_port = p; wr_byte = b;
    @(posedge clk); #2;
    wr_strobe = 1'b0;
  endtask

  task automatic rd();
    rd_strobe = 1'b1;
    @(posedge clk); #2;
    rd_strobe = 1'b0;
  endtask

  task automatic wr_rd(input bit p, input logic [7:0] b);
    wr_strobe = 1'b1; wr_port = p; wr_byte = b; rd_strobe = 1'b1;
    @(posedge clk); #2;
    wr_strobe = 1'b0; rd_strobe = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [7:0] v);
    wr(1'b0, a);
    wr(1'b1, v);
  endtask

  task automatic send_key(input int n);
    for (int i = 0; i < n; i++) wr(1'b0, key_tab[i]);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [71:0] got;
    b = 8'h6A;
    for (int i = 0; i < 32; i++) begin
      key_tab[i] = b;
      b = (b >> 1) | (((b ^ (b >> 1)) & 8'h01) << 7);
    end

    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    live = 1;
    @(posedge clk); #2;

    cur_req = "R1";
    check(cfg_open == 0 && isolating == 0, "R1", "open/iso after reset", {cfg_open, isolating}, 0);
    check(card_number == 0 && logical_dev == 0 && dev_active == 0, "R1", "regs after reset",
          {card_number, logical_dev, dev_active}, 0);
    check(rd_byte == 8'hFF, "R1", "rd_byte after reset", rd_byte, 8'hFF);

    cur_req = "R5";
    reg_wr(8'h06, 8'h77);
    wr(1'b1, 8'h33);
    check(card_number == 0 && cfg_open == 0, "R5", "locked data write", card_number, 0);

    cur_req = "R2";
    wr(1'b0, 8'h11);
    send_key(32);
    check(cfg_open == 0, "R2", "key without arming", cfg_open, 0);
    wr(1'b0, 8'h00); wr(1'b0, 8'h5A); wr(1'b0, 8'h00);
    send_key(32);
    check(cfg_open == 0, "R2", "zeros not consecutive", cfg_open, 0);

    cur_req = "R4";
    wr(1'b0, 8'h00); wr(1'b0, 8'h00);
    send_key(5);
    wr(1'b0, 8'h12);
    send_key(1);
    wr(1'b0, key_tab[2]);
    check(cfg_open == 0, "R4", "mismatch restarts key", cfg_open, 0);
    wr(1'b0, 8'h00); wr(1'b0, 8'h00);
    send_key(31);
    wr(1'b0, 8'hFF);
    check(cfg_open == 0, "R4", "last byte wrong", cfg_open, 0);

    cur_req = "R3";
    check(key_tab[31] == 8'h39, "R3", "computed last key byte", key_tab[31], 8'h39);
    send_key(31);
    check(cfg_open == 0, "R3", "open before last byte", cfg_open, 0);
    wr(1'b0, key_tab[31]);
    check(cfg_open == 1, "R3", "open after full key", cfg_open, 1);

    cur_req = "R12";
    wr(1'b0, 8'h00); wr(1'b0, 8'h00); wr(1'b0, 8'h6A); wr(1'b0, 8'hC3);
    check(cfg_open == 1, "R12", "stays open", cfg_open, 1);

    cur_req = "R6";
    reg_wr(8'h06, 8'h2C);
    check(card_number == 8'h2C, "R6", "card number", card_number, 8'h2C);
    reg_wr(8'h07, 8'h03);
    check(logical_dev == 8'h03, "R6", "logical device", logical_dev, 8'h03);

    cur_req = "R7";
    reg_wr(8'h30, 8'h01);
    check(dev_active == 8'h08, "R7", "activate dev 3", dev_active, 8'h08);
    reg_wr(8'h07, 8'h09);
    reg_wr(8'h30, 8'h01);
    check(dev_active == 8'h08, "R7", "out-of-range device ignored", dev_active, 8'h08);
    reg_wr(8'h07, 8'h00);
    reg_wr(8'h30, 8'h03);
    check(dev_active == 8'h09, "R7", "activate dev 0", dev_active, 8'h09);
    wr(1'b1, 8'h02);
    check(dev_active == 8'h08, "R7", "deactivate dev 0", dev_active, 8'h08);

    cur_req = "R8";
    rd();
    check(rd_byte == 8'hFF, "R8", "read before isolation", rd_byte, 8'hFF);
    reg_wr(8'h01, 8'h01);
    check(isolating == 0, "R8", "isolation without read-port setup", isolating, 0);
    reg_wr(8'h00, 8'h80);
    reg_wr(8'h01, 8'h02);
    check(isolating == 0, "R8", "wrong isolation command", isolating, 0);
    wr(1'b1, 8'h01);
    check(isolating == 1, "R8", "isolation started", isolating, 1);

    cur_req = "R9";
    got = '0;
    for (int k = 0; k < 72; k++) begin
      rd();
      check(rd_byte == (ID[k] ? 8'h55 : 8'h00), "R9", $sformatf("first read bit %0d", k),
            rd_byte, ID[k] ? 8'h55 : 8'h00);
      rd();
      check(rd_byte == (ID[k] ? 8'hAA : 8'h00), "R9", $sformatf("second read bit %0d", k),
            rd_byte, ID[k] ? 8'hAA : 8'h00);
      got[k] = (rd_byte == 8'hAA);
    end
    check(got == ID, "R9", "assembled identifier", got, ID);

    cur_req = "R10";
    check(isolating == 0, "R10", "isolation ended", isolating, 0);
    rd();
    check(rd_byte == 8'hFF, "R10", "read after end", rd_byte, 8'hFF);

    cur_req = "R11";
    wr(1'b1, 8'h01);
    for (int i = 0; i < 7; i++) rd();
    wr_rd(1'b1, 8'h01);
    check(rd_byte == (ID[3] ? 8'hAA : 8'h00), "R11", "concurrent read uses old position",
          rd_byte, ID[3] ? 8'hAA : 8'h00);
    rd();
    check(rd_byte == (ID[0] ? 8'h55 : 8'h00), "R11", "restart at bit 0",
          rd_byte, ID[0] ? 8'h55 : 8'h00);

    repeat (2) @(posedge clk);
    #2;
    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end

endmodule